// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the address for each beat of a four-beat burst on a synchronous memory port. A load cycle captures a full address. The upper bits are passed straight through for the whole burst. The two low bits seed a base value. Each later continue cycle moves an internal beat count forward by one, and the low address bits come from that count and the base.

An ordering select picks how the low bits are formed. In linear ordering the base is added to the beat count modulo four. In interleaved ordering the base is XORed with the beat count. In both orderings the fifth access lands back on the base address. An active-low clock enable freezes all state: an edge with the enable deasserted is ignored.

The ordering select is a plain static control pin and is sampled combinationally. It is expected to change only between bursts. There is no data stream, so the block has no valid/ready handshake. Every pin is a plain control or address pin that acts on the rising clock edge. Reset is synchronous and active low.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next value of `burst_addr` is all zeros. This means base zero and beat count zero.
- R2: A rising edge with `clk_en_n` = 0 and `adv_ld_n` = 0 loads the address, and the next `burst_addr` equals `load_addr` in either ordering (beat count 0).
- R3: A rising edge with `clk_en_n` = 0 and `adv_ld_n` = 1 advances the beat count by exactly one, modulo 4.
- R4: With `order_sel` = 0 (linear), `burst_addr[1:0]` = (base + beat) mod 4.
- R5: With `order_sel` = 1 (interleaved), `burst_addr[1:0]` = base XOR beat.
- R6: After a load followed by four advances, `burst_addr` equals the loaded address again in both orderings.
- R7: A rising edge with `clk_en_n` = 1 changes nothing: `burst_addr` holds whatever `adv_ld_n` and `load_addr` are.
- R8: `burst_addr[ADDR_W-1:2]` always equals the upper bits of the most recently loaded address, and advances never alter them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the sequencer |
| adv_ld_n | input | 1 | Low loads `load_addr`; high advances the burst |
| order_sel | input | 1 | 0 = linear ordering, 1 = interleaved ordering (held static) |
| load_addr | input | ADDR_W | Address captured on a load cycle |
| burst_addr | output | ADDR_W | Address of the current beat |

## Verification
The bench builds the block with `ADDR_W` = 8. This leaves six upper bits, so random loads cover every low-bit base and many upper patterns within a few hundred cycles. Directed bursts walk every beat of both orderings through the wrap. Random stretches mix loads, advances and frozen edges with the order select changed only at loads. This exercises frozen edges in the middle of a burst and back-to-back loads.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (clear) begin
      beat <= '0;
    end else if (step) begin
      beat <= beat + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              interleave,
  input  logic [BEAT_W-1:0] base_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] addr_lo
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = base_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = base_lo[b] ^ beat[b];
  end

  always_comb begin
    addr_lo = interleave ? xor_lo : lin_lo;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              adv_ld_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int unsigned LO_W = BEAT_W;
  localparam int unsigned HI_W = ADDR_W - LO_W;

  logic        edge_live;
  logic        do_load;
  logic        do_step;
  logic [ADDR_W-1:0] base_q;
  beat_t       beat;
  beat_t       lo_addr;
  order_e      order;

  assign edge_live = !clk_en_n;
  assign do_load   = edge_live && !adv_ld_n;
  assign do_step   = edge_live && adv_ld_n;
  assign order     = order_e'(order_sel);

  burst_base_reg #(.ADDR_W(ADDR_W)) base_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (do_load),
    .addr_in (load_addr),
    .addr_q  (base_q)
  );

  burst_beat_ctr #(.BEAT_W(LO_W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (do_load),
    .step  (do_step),
    .beat  (beat)
  );

  burst_order_map #(.BEAT_W(LO_W)) map_i (
    .interleave (order == ORDER_INTERLEAVED),
    .base_lo    (base_q[LO_W-1:0]),
    .beat       (beat),
    .addr_lo    (lo_addr)
  );

  assign burst_addr = {base_q[ADDR_W-1 -: HI_W], lo_addr};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              adv_ld_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] load_addr,
  input logic [ADDR_W-1:0] burst_addr
);
  logic [1:0] seen_base;
  logic [1:0] lo_now;
  logic [1:0] beat_seen;

  assign lo_now    = burst_addr[1:0];
  assign beat_seen = lo_now ^ seen_base;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_base <= 2'b00;
    else if (!clk_en_n && !adv_ld_n) seen_base <= load_addr[1:0];
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> burst_addr == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld_n) |=> burst_addr == $past(load_addr));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld_n && !order_sel) |=>
      (order_sel || lo_now == 2'($past(lo_now) + 2'd1)));

  assert_xor_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld_n && order_sel) |=>
      (!order_sel || beat_seen == 2'($past(beat_seen) + 2'd1)));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(burst_addr) || !$stable(order_sel)));

  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld_n) |=>
      burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n;
  logic          adv_ld_n;
  logic          order_sel;
  logic [AW-1:0] load_addr;
  logic [AW-1:0] burst_addr;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .adv_ld_n   (adv_ld_n),
    .order_sel  (order_sel),
    .load_addr  (load_addr),
    .burst_addr (burst_addr)
  );

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] base,
                                                input logic [1:0] beat,
                                                input logic ord);
    logic [1:0] lo;
    lo = ord ? (base[1:0] ^ beat) : 2'(base[1:0] + beat);
    return {base[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got,
                       input logic [AW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic cen, input logic adv, input logic ord,
                      input logic [AW-1:0] a, input string tag);
    clk_en_n  = cen;
    adv_ld_n  = adv;
    order_sel = ord;
    load_addr = a;
    @(posedge clk);
    if (!cen) begin
      if (!adv) begin
        m_base = a;
        m_beat = 2'd0;
      end else begin
        m_beat = m_beat + 2'd1;
      end
    end
    @(negedge clk);
    check(tag, burst_addr, expect_addr(m_base, m_beat, ord));
    check("R8", {burst_addr[AW-1:2], 2'b00}, {m_base[AW-1:2], 2'b00});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic ord_r;
    void'($urandom(32'd4242));
    rst_n     = 1'b0;
    clk_en_n  = 1'b0;
    adv_ld_n  = 1'b0;
    order_sel = 1'b0;
    load_addr = 8'h5B;
    m_base    = '0;
    m_beat    = 2'd0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1 reset", burst_addr, 8'h00);
    rst_n = 1'b1;

    // Linear burst from base 2: A6 A7 A4 A5 then wrap to A6
    step(1'b0, 1'b0, 1'b0, 8'hA6, "R2 load linear");
    step(1'b0, 1'b1, 1'b0, 8'h00, "R3 R4 beat1");
    step(1'b0, 1'b1, 1'b0, 8'hFF, "R4 beat2");
    step(1'b0, 1'b1, 1'b0, 8'h11, "R4 beat3");
    step(1'b0, 1'b1, 1'b0, 8'h22, "R6 wrap linear");
    check("R6 wrap value", burst_addr, 8'hA6);

    // Frozen edges: neither load nor advance takes effect
    step(1'b1, 1'b0, 1'b0, 8'h33, "R7 freeze load");
    step(1'b1, 1'b1, 1'b0, 8'h44, "R7 freeze advance");
    check("R7 held", burst_addr, 8'hA6);

    // Interleaved burst from base 1: 3D 3C 3F 3E then wrap to 3D
    step(1'b0, 1'b0, 1'b1, 8'h3D, "R2 load interleaved");
    step(1'b0, 1'b1, 1'b1, 8'h00, "R3 R5 beat1");
    check("R5 beat1 value", burst_addr, 8'h3C);
    step(1'b1, 1'b1, 1'b1, 8'h00, "R7 stall mid burst");
    step(1'b0, 1'b1, 1'b1, 8'h00, "R5 beat2");
    check("R5 beat2 value", burst_addr, 8'h3F);
    step(1'b0, 1'b1, 1'b1, 8'h00, "R5 beat3");
    step(1'b0, 1'b1, 1'b1, 8'h00, "R6 wrap interleaved");
    check("R6 wrap value", burst_addr, 8'h3D);

    // Random mix; order select changes only on load edges
    ord_r = 1'b1;
    for (int i = 0; i < 800; i++) begin
      logic cen;
      logic adv;
      cen = ($urandom % 5) == 0;
      adv = ($urandom % 4) != 0;
      if (!cen && !adv && ($urandom % 3) == 0) ord_r = ~ord_r;
      step(cen, adv, ord_r, AW'($urandom), cen ? "R7 random" :
           (!adv ? "R2 random" : (ord_r ? "R5 random" : "R4 random")));
    end
    finish_run();
  end
endmodule